// File: doc/BRIEF.md
# Two-Accumulator Byte-Coded Processor Core

This block is a compact 16-bit processor core. All arithmetic happens between two working registers, called the primary and secondary accumulators (r1 and r2). Six general 16-bit registers sit beside them. Every opcode is one byte, fetched from a byte-wide synchronous memory that holds both program and data. Load and store opcodes name an operand location through a six-bit field. That location can be a general register, an inline constant, memory addressed by a general register, or an inline memory address. The field also sets the width of the transfer and the width of the inline operand, and the two widths are independent.

Execute opcodes combine the two accumulators, update the carry and zero flags, or jump to the address held in r1. A jump can be unconditional or depend on one flag. One execute code stops the core; it then stays stopped until reset. The core runs one state per memory access. A byte read is issued in one cycle and its data is used in the next.

Top module: `duo_acc_core`

## Requirements
- R1: After a synchronous active-low reset, PC, r1, r2, both flags and all general registers are zero. The first fetch is from address 0. Write enable and halted are low.
- R2: Opcode bits [7:6] give the class: 00 loads r1, 01 loads r2, 10 executes, 11 stores r1. For load and store, bit 5 is the transfer width (0 = 8, 1 = 16). Bits [4:3] are the mode: 00 register, 01 immediate, 10 register-indirect, 11 absolute. Bits [2:0] are the register index in the register modes. In the immediate and absolute modes, bit 2 is the inline operand width (0 = one byte, 1 = two bytes).
- R3: Inline operands follow the opcode, low byte first. An 8-bit transfer keeps only the low byte of the operand and zero-fills the upper byte of the destination.
- R4: A 16-bit memory access covers two consecutive bytes, with the low byte at the lower address. An 8-bit load zero-extends the byte. An 8-bit store writes only the low byte of r1.
- R5: Register-indirect mode uses the value of the indexed general register as the memory address.
- R6: Indices 0 to 5 select general registers. Indices 6 and 7 read as zero and ignore writes. A register store with an 8-bit transfer writes the low byte of r1, zero-extended.
- R7: Execute codes 0 AND, 1 OR, 2 XOR, 4 ADD and 5 SUB (r1 minus r2) write their 16-bit result into r1.
- R8: Z is set when the 16-bit result is zero. C is the carry out of ADD, or the borrow of SUB and of code 3 (compare). Compare updates only the flags. The logic operations clear C.
- R9: Code 6 loads PC from r1. Codes 7, 8, 9 and 10 do so only when C=0, C=1, Z=0 and Z=1 respectively.
- R10: Execute codes 11 to 62 change nothing. Code 63 halts the core: halted rises and stays high, and no further memory write occurs.
- R11: A store in immediate mode consumes its operand bytes and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Byte address for the current access |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | Write strobe for this cycle |
| mem_rdata | input | 8 | Byte read from the address of the previous cycle |
| halted | output | 1 | High once the halt code has executed |

## Verification
The assertions assume a memory that returns, one cycle later, the byte at the address presented, and that holds no write other than the core's own. The bench models exactly that memory inside its own array. The test program keeps its code below the bytes it stores to. Every jump in the program lands on a real opcode boundary, so the flag and jump checks always see well-formed instruction streams.

// File: rtl/duo_pkg.sv
package duo_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  localparam logic [1:0] CLS_LD1 = 2'b00;
  localparam logic [1:0] CLS_LD2 = 2'b01;
  localparam logic [1:0] CLS_EXE = 2'b10;
  localparam logic [1:0] CLS_ST1 = 2'b11;

  localparam logic [1:0] MODE_REG = 2'b00;
  localparam logic [1:0] MODE_IMM = 2'b01;
  localparam logic [1:0] MODE_IND = 2'b10;
  localparam logic [1:0] MODE_ABS = 2'b11;

  localparam logic [5:0] OP_AND  = 6'd0;
  localparam logic [5:0] OP_OR   = 6'd1;
  localparam logic [5:0] OP_XOR  = 6'd2;
  localparam logic [5:0] OP_CMP  = 6'd3;
  localparam logic [5:0] OP_ADD  = 6'd4;
  localparam logic [5:0] OP_SUB  = 6'd5;
  localparam logic [5:0] OP_JMP  = 6'd6;
  localparam logic [5:0] OP_JC0  = 6'd7;
  localparam logic [5:0] OP_JC1  = 6'd8;
  localparam logic [5:0] OP_JZ0  = 6'd9;
  localparam logic [5:0] OP_JZ1  = 6'd10;
  localparam logic [5:0] OP_HALT = 6'd63;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_OPND0, ST_OPND1,
    ST_MEM0, ST_MEM1, ST_MEM2, ST_HALT
  } state_t;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic              c;
    logic              z;
    logic              wr_r1;
    logic              upd_flags;
    logic              is_logic;
  } alu_out_t;

  function automatic alu_out_t alu_eval(input logic [5:0] op,
                                        input logic [WORD_W-1:0] a,
                                        input logic [WORD_W-1:0] b);
    alu_out_t o;
    logic [WORD_W:0] wide;
    o = '0;
    wide = '0;
    unique case (op)
      OP_AND: begin o.res = a & b; o.wr_r1 = 1'b1; o.upd_flags = 1'b1; o.is_logic = 1'b1; end
      OP_OR:  begin o.res = a | b; o.wr_r1 = 1'b1; o.upd_flags = 1'b1; o.is_logic = 1'b1; end
      OP_XOR: begin o.res = a ^ b; o.wr_r1 = 1'b1; o.upd_flags = 1'b1; o.is_logic = 1'b1; end
      OP_CMP, OP_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        o.res = wide[WORD_W-1:0];
        o.c = wide[WORD_W];
        o.wr_r1 = (op == OP_SUB);
        o.upd_flags = 1'b1;
      end
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        o.res = wide[WORD_W-1:0];
        o.c = wide[WORD_W];
        o.wr_r1 = 1'b1;
        o.upd_flags = 1'b1;
      end
      default: o = '0;
    endcase
    o.z = (o.res == '0);
    return o;
  endfunction

  function automatic logic jump_taken(input logic [5:0] op, input logic c, input logic z);
    return (op == OP_JMP) || (op == OP_JC0 && !c) || (op == OP_JC1 && c) ||
           (op == OP_JZ0 && !z) || (op == OP_JZ1 && z);
  endfunction
endpackage

// File: rtl/duo_gregs.sv
module duo_gregs #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3,
  parameter int W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && widx == IDX_W'(g))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ridx == IDX_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/duo_alu.sv
module duo_alu
  import duo_pkg::*;
(
  input  logic [5:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              c_in,
  input  logic              z_in,
  output alu_out_t          res,
  output logic              take_jump
);
  always_comb begin
    res       = alu_eval(op, a, b);
    take_jump = jump_taken(op, c_in, z_in);
  end
endmodule

// File: rtl/duo_acc_core.sv
module duo_acc_core
  import duo_pkg::*;
#(
  parameter int NUM_GREGS = 6,
  parameter int IDX_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  output logic               mem_we,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               halted
);
  localparam int HB = WORD_W - BYTE_W;

  state_t            state_q;
  logic [WORD_W-1:0] pc_q, r1_q, r2_q, ea_q;
  logic [BYTE_W-1:0] ir_q, lo_q;
  logic              flag_c_q, flag_z_q;

  logic [1:0]        cls, mode;
  logic              xw, ow, is_load, is_store, inline_mode;
  logic [IDX_W-1:0]  ridx;
  logic [5:0]        xop;
  assign cls  = ir_q[7:6];
  assign xw   = ir_q[5];
  assign mode = ir_q[4:3];
  assign ow   = ir_q[2];
  assign ridx = ir_q[IDX_W-1:0];
  assign xop  = ir_q[5:0];
  assign is_load  = (cls == CLS_LD1) || (cls == CLS_LD2);
  assign is_store = (cls == CLS_ST1);
  assign inline_mode = (mode == MODE_IMM) || (mode == MODE_ABS);

  logic [WORD_W-1:0] greg_rd, greg_wd;
  logic              greg_we;
  duo_gregs #(.NUM_REGS(NUM_GREGS), .IDX_W(IDX_W), .W(WORD_W)) u_gregs (
    .clk(clk), .rst_n(rst_n), .we(greg_we), .widx(ridx), .wdata(greg_wd),
    .ridx(ridx), .rdata(greg_rd)
  );

  alu_out_t alu_o;
  logic     alu_jump;
  duo_alu u_alu (
    .op(xop), .a(r1_q), .b(r2_q), .c_in(flag_c_q), .z_in(flag_z_q),
    .res(alu_o), .take_jump(alu_jump)
  );

  // Named events for the checker
  logic in_exec_op, ev_alu_wr, ev_jump, ev_logic;
  assign in_exec_op = (state_q == ST_EXEC) && (cls == CLS_EXE);
  assign ev_alu_wr  = in_exec_op && alu_o.wr_r1;
  assign ev_jump    = in_exec_op && alu_jump;
  assign ev_logic   = in_exec_op && alu_o.is_logic;

  // Load completion: one place where a loaded value becomes final
  logic              ld_fire;
  logic [WORD_W-1:0] ld_raw, ld_val;
  always_comb begin
    ld_fire = 1'b0;
    ld_raw  = '0;
    if (is_load) begin
      unique case (state_q)
        ST_EXEC:  if (mode == MODE_REG) begin ld_fire = 1'b1; ld_raw = greg_rd; end
        ST_OPND0: if (mode == MODE_IMM && !ow) begin ld_fire = 1'b1; ld_raw = {{HB{1'b0}}, mem_rdata}; end
        ST_OPND1: if (mode == MODE_IMM) begin ld_fire = 1'b1; ld_raw = {mem_rdata, lo_q}; end
        ST_MEM1:  if (!xw) begin ld_fire = 1'b1; ld_raw = {{HB{1'b0}}, mem_rdata}; end
        ST_MEM2:  begin ld_fire = 1'b1; ld_raw = {mem_rdata, lo_q}; end
        default:  ld_fire = 1'b0;
      endcase
    end
    ld_val = xw ? ld_raw : {{HB{1'b0}}, ld_raw[BYTE_W-1:0]};
  end

  assign greg_we = (state_q == ST_EXEC) && is_store && (mode == MODE_REG);
  assign greg_wd = xw ? r1_q : {{HB{1'b0}}, r1_q[BYTE_W-1:0]};

  // Memory port
  always_comb begin
    mem_addr  = pc_q;
    mem_we    = 1'b0;
    mem_wdata = r1_q[BYTE_W-1:0];
    unique case (state_q)
      ST_MEM0: begin
        mem_addr = ea_q;
        mem_we   = is_store;
      end
      ST_MEM1: begin
        mem_addr  = ea_q + WORD_W'(1);
        mem_we    = is_store;
        mem_wdata = r1_q[WORD_W-1:HB];
      end
      default: mem_addr = pc_q;
    endcase
  end

  assign halted = (state_q == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_FETCH;
      pc_q     <= '0;
      r1_q     <= '0;
      r2_q     <= '0;
      ea_q     <= '0;
      ir_q     <= '0;
      lo_q     <= '0;
      flag_c_q <= 1'b0;
      flag_z_q <= 1'b0;
    end else begin
      if (ld_fire) begin
        if (cls == CLS_LD1) r1_q <= ld_val;
        else                r2_q <= ld_val;
      end
      unique case (state_q)
        ST_FETCH: begin
          pc_q    <= pc_q + WORD_W'(1);
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          ir_q    <= mem_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          state_q <= ST_FETCH;
          if (cls == CLS_EXE) begin
            if (alu_o.wr_r1) r1_q <= alu_o.res;
            if (alu_o.upd_flags) begin
              flag_c_q <= alu_o.c;
              flag_z_q <= alu_o.z;
            end
            if (alu_jump) pc_q <= r1_q;
            if (xop == OP_HALT) state_q <= ST_HALT;
          end else if (mode == MODE_IND) begin
            ea_q    <= greg_rd;
            state_q <= ST_MEM0;
          end else if (inline_mode) begin
            pc_q    <= pc_q + WORD_W'(1);
            state_q <= ST_OPND0;
          end
        end
        ST_OPND0: begin
          lo_q <= mem_rdata;
          if (ow) begin
            pc_q    <= pc_q + WORD_W'(1);
            state_q <= ST_OPND1;
          end else if (mode == MODE_ABS) begin
            ea_q    <= {{HB{1'b0}}, mem_rdata};
            state_q <= ST_MEM0;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_OPND1: begin
          if (mode == MODE_ABS) begin
            ea_q    <= {mem_rdata, lo_q};
            state_q <= ST_MEM0;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_MEM0: state_q <= (is_store && !xw) ? ST_FETCH : ST_MEM1;
        ST_MEM1: begin
          lo_q    <= mem_rdata;
          state_q <= (is_load && xw) ? ST_MEM2 : ST_FETCH;
        end
        ST_MEM2: state_q <= ST_FETCH;
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/duo_acc_core_chk.sv
module duo_acc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        mem_we,
  input logic [1:0]  ir_cls,
  input logic [15:0] pc,
  input logic [15:0] r1,
  input logic        fc,
  input logic        fz,
  input logic        ev_alu_wr,
  input logic        ev_jump,
  input logic        ev_logic
);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we));

  // R2
  write_from_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ir_cls == 2'b11));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alu_wr |=> (fz == (r1 == 16'h0000)));

  // R8
  logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> !fc);

  // R9
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> (pc == $past(r1)));
endmodule

bind duo_acc_core duo_acc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_we(mem_we),
  .ir_cls(ir_q[7:6]), .pc(pc_q), .r1(r1_q), .fc(flag_c_q), .fz(flag_z_q),
  .ev_alu_wr(ev_alu_wr), .ev_jump(ev_jump), .ev_logic(ev_logic)
);

// File: tb/duo_acc_core_test.sv
module duo_acc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 1024;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, halted;

  duo_acc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [MEM_BYTES];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } wr_item_t;
  wr_item_t expq[$];

  int checks = 0;
  int errors = 0;
  int ap = 0;

  task automatic e1(input logic [7:0] b);
    mem[ap] = b; ap++;
  endtask
  task automatic e2(input logic [7:0] b0, input logic [7:0] b1);
    e1(b0); e1(b1);
  endtask
  task automatic e3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    e1(b0); e1(b1); e1(b2);
  endtask
  task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    wr_item_t it;
    it.addr = a; it.data = d; it.req = req;
    expq.push_back(it);
  endtask
  // Load r1 with a target seven bytes ahead (ld, jump op, one skipped 3-byte store)
  task automatic jump_over_bad(input logic [7:0] jop);
    int t;
    t = ap + 7;
    e3(8'h2C, 8'(t), 8'(t >> 8));
    e1(jop);
    e3(8'hDC, 8'hF0, 8'h02);
  endtask
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every write must match the next expected write
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) begin
        check(1'b0, "R10", "unexpected write addr", int'(mem_addr), 0);
      end else begin
        wr_item_t it;
        it = expq.pop_front();
        check(mem_addr == it.addr && mem_wdata == it.data, it.req,
              $sformatf("write @%0h", it.addr),
              int'({mem_addr, mem_wdata}), int'({it.addr, it.data}));
      end
    end
  end

  task automatic build_program();
    int t;
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    mem[10'h300] = 8'h5A;
    mem[10'h301] = 8'hA5;
    // R3 R4: 16-bit immediate into r1, 16-bit store to abs16 0x0200
    e3(8'h2C, 8'h34, 8'h12); e3(8'hFC, 8'h00, 8'h02);
    expect_wr(16'h0200, 8'h34, "R4"); expect_wr(16'h0201, 8'h12, "R4");
    // R7 ADD: r2=0x00FF, r1=0x1333; 8-bit store to abs8 0xFE
    e2(8'h68, 8'hFF); e1(8'h84); e2(8'hD8, 8'hFE);
    expect_wr(16'h00FE, 8'h33, "R4");
    // R6: store to reg2, store to reg7 (ignored), load reg7 reads zero
    e1(8'hE2); e1(8'hE7); e1(8'h27); e3(8'hFC, 8'h02, 8'h02);
    expect_wr(16'h0202, 8'h00, "R6"); expect_wr(16'h0203, 8'h00, "R6");
    // R2 R3: 8-bit transfer from reg2 clears upper byte
    e1(8'h02); e3(8'hFC, 8'h04, 8'h02);
    expect_wr(16'h0204, 8'h33, "R2"); expect_wr(16'h0205, 8'h00, "R3");
    // R5: reg3=0x0210, indirect 16-bit store of 0xBEEF
    e3(8'h2C, 8'h10, 8'h02); e1(8'hE3); e3(8'h2C, 8'hEF, 8'hBE); e1(8'hF3);
    expect_wr(16'h0210, 8'hEF, "R5"); expect_wr(16'h0211, 8'hBE, "R5");
    // R5: 8-bit indirect load into r2, moved to r1 via OR with zero
    e1(8'h53); e2(8'h28, 8'h00); e1(8'h81); e3(8'hFC, 8'h06, 8'h02);
    expect_wr(16'h0206, 8'hEF, "R5"); expect_wr(16'h0207, 8'h00, "R5");
    // R5: 16-bit indirect load
    e1(8'h33); e3(8'hFC, 8'h08, 8'h02);
    expect_wr(16'h0208, 8'hEF, "R5"); expect_wr(16'h0209, 8'hBE, "R5");
    // R7 R8 SUB with borrow: 0xBEEF-0xBEF0 = 0xFFFF, C=1
    e3(8'h6C, 8'hF0, 8'hBE); e1(8'h85); e3(8'hFC, 8'h0A, 8'h02);
    expect_wr(16'h020A, 8'hFF, "R7"); expect_wr(16'h020B, 8'hFF, "R7");
    // R11: store to immediate writes nothing
    e2(8'hC8, 8'h77);
    // R9: JC1 taken (C=1)
    jump_over_bad(8'h88);
    // R9: JC0 not taken, following store must happen
    t = ap + 7;
    e3(8'h2C, 8'(t), 8'(t >> 8)); e1(8'h87); e3(8'hDC, 8'h0C, 8'h02);
    expect_wr(16'h020C, 8'(t), "R9");
    // R8: compare 5 with 5 keeps r1, sets Z
    e2(8'h28, 8'h05); e2(8'h68, 8'h05); e1(8'h83); e3(8'hDC, 8'h0F, 8'h02);
    expect_wr(16'h020F, 8'h05, "R8");
    jump_over_bad(8'h8A);  // R9 JZ1 taken
    t = ap + 7;            // R9 JZ0 not taken
    e3(8'h2C, 8'(t), 8'(t >> 8)); e1(8'h89); e3(8'hDC, 8'h0E, 8'h02);
    expect_wr(16'h020E, 8'(t), "R9");
    // R8: set C by 0-1, then AND clears C, so JC0 is taken
    e2(8'h28, 8'h00); e2(8'h68, 8'h01); e1(8'h85); e1(8'h80);
    jump_over_bad(8'h87);
    // R7 XOR: 0x00FF ^ 0x0F0F = 0x0FF0
    e3(8'h2C, 8'hFF, 8'h00); e3(8'h6C, 8'h0F, 8'h0F); e1(8'h82); e3(8'hFC, 8'h14, 8'h02);
    expect_wr(16'h0214, 8'hF0, "R7"); expect_wr(16'h0215, 8'h0F, "R7");
    // R8 ADD carry: 0xFFFF+2 = 0x0001, C=1, JC1 taken
    e3(8'h2C, 8'hFF, 8'hFF); e2(8'h68, 8'h02); e1(8'h84); e3(8'hFC, 8'h16, 8'h02);
    expect_wr(16'h0216, 8'h01, "R8"); expect_wr(16'h0217, 8'h00, "R8");
    jump_over_bad(8'h88);
    jump_over_bad(8'h86);  // R9 unconditional
    // R3: 16-bit immediate with 8-bit transfer keeps low byte
    e3(8'h0C, 8'hCD, 8'hAB); e3(8'hFC, 8'h18, 8'h02);
    expect_wr(16'h0218, 8'hCD, "R3"); expect_wr(16'h0219, 8'h00, "R3");
    // R4: absolute loads, 16-bit and 8-bit transfer
    e3(8'h3C, 8'h00, 8'h03); e3(8'hFC, 8'h1A, 8'h02);
    expect_wr(16'h021A, 8'h5A, "R4"); expect_wr(16'h021B, 8'hA5, "R4");
    e3(8'h1C, 8'h01, 8'h03); e3(8'hFC, 8'h1C, 8'h02);
    expect_wr(16'h021C, 8'hA5, "R4"); expect_wr(16'h021D, 8'h00, "R4");
    // R10: code 20 is a no-op
    e1(8'h94); e3(8'hFC, 8'h1E, 8'h02);
    expect_wr(16'h021E, 8'hA5, "R10"); expect_wr(16'h021F, 8'h00, "R10");
    // R4: abs8 16-bit load from 0xFE (0x33, 0x00)
    e2(8'h38, 8'hFE); e3(8'hFC, 8'h20, 8'h02);
    expect_wr(16'h0220, 8'h33, "R4"); expect_wr(16'h0221, 8'h00, "R4");
    // R10: halt, then a store that must never run
    e1(8'hBF); e3(8'hDC, 8'hF0, 8'h02);
  endtask

  initial begin
    int cyc;
    build_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(mem_addr == 16'h0000, "R1", "reset mem_addr", int'(mem_addr), 0);
    check(mem_we == 1'b0, "R1", "reset mem_we", int'(mem_we), 0);
    check(halted == 1'b0, "R1", "reset halted", int'(halted), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < WATCHDOG) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < WATCHDOG, "R10", "watchdog (halt reached)", cyc, WATCHDOG);
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R10", "halted stays high", int'(halted), 1);
    check(expq.size() == 0, "R2", "expected writes outstanding", expq.size(), 0);
    check(mem[10'h2F0] == 8'h00, "R9", "skipped store untouched", int'(mem[10'h2F0]), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule